// File: doc/BRIEF.md
# Negabinary Two-Operand Adder

This block adds two unsigned-digit numbers written in radix -2. The digit at position k carries the weight (-2)^k. Even positions therefore count positively and odd positions count negatively, and the same digit vector can stand for both positive and negative values without a separate sign bit. The adder is purely combinational. Operands go in, and a sum in the same radix comes out in the same evaluation, together with a flag that reports when the exact result does not fit.

The datapath has two rows of cells. The first row is a chain of full adders that are made sign-aware with inverters. It combines both operand digits with a carry that enters each position at the opposite polarity. Every sum digit leaves this row with the wrong sign for its position. A second row of sign-aware half adders turns those digits back into proper radix -2 form and has a carry chain of its own. The flag is derived from the carries that leave the top of the two chains.

Top module: `negabinAdder`

## Requirements
- R1: The digit vector `sum` has the value Σ sum[k]·(-2)^k. When `overflow` is 0, this value equals the sum of the values of `opA` and `opB`, each evaluated with the same weights.
- R2: For WIDTH digits, the largest representable value is the sum of the even-position weights and the smallest is the sum of the odd-position weights. With the default of 6 digits the range is -42 to 21. `overflow` is 1 exactly when the true sum lies outside this range.
- R3: When `overflow` is 1, `sum` holds the single representable value that is congruent to the true sum modulo 2^WIDTH. That value differs from the true sum by exactly +2^WIDTH or -2^WIDTH.
- R4: When `opA` is all zeros, `sum` equals `opB` and `overflow` is 0. When both operands are zero, both outputs are zero.
- R5: Digit 0 of `sum` equals opA[0] XOR opB[0].
- R6: Swapping `opA` and `opB` leaves `sum` and `overflow` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand, radix -2 digits, bit k has weight (-2)^k |
| opB | input | WIDTH | Second operand, same encoding as opA |
| sum | output | WIDTH | Result digits in radix -2 |
| overflow | output | 1 | High when the exact sum is outside the representable range |

## Verification
The bench builds the adder at its default width of 6 digits. At that width all 4096 operand pairs can be applied, so every carry pattern through both chains is reached. This includes the wrap at both ends of the asymmetric range (-42 and 21) and every pair that overflows in either direction. A short table of hand-worked vectors, applied both as written and with the operands swapped, pins down the extreme values and the commutation property before the exhaustive sweep begins.

// File: rtl/negabinPkg.sv
package negabinPkg;

  typedef enum logic {
    GHA_NEG_SUM   = 1'b0,
    GHA_NEG_CARRY = 1'b1
  } ghaVariantE;

  // weight of digit k in radix -2
  function automatic int nbWeight(input int k);
    int w;
    w = 1;
    for (int i = 0; i < k; i++) w = -2 * w;
    return w;
  endfunction

  // value of a digit vector of width w
  function automatic int nbToInt(input logic [31:0] digits, input int w);
    int acc;
    acc = 0;
    for (int i = 0; i < w; i++) begin
      if (digits[i]) acc += nbWeight(i);
    end
    return acc;
  endfunction

  function automatic int nbMaxVal(input int w);
    int acc;
    acc = 0;
    for (int i = 0; i < w; i += 2) acc += nbWeight(i);
    return acc;
  endfunction

  function automatic int nbMinVal(input int w);
    int acc;
    acc = 0;
    for (int i = 1; i < w; i += 2) acc += nbWeight(i);
    return acc;
  endfunction

endpackage

// File: rtl/nbGfaCell.sv
// Full adder with per-input sign. Inputs marked negative are inverted
// before a plain full adder. The outputs are inverted according to how
// many inputs were negative.
module nbGfaCell #(
  parameter logic [2:0] NEG_MASK = 3'b100
) (
  input  logic inA,
  input  logic inB,
  input  logic inC,
  output logic sumBit,
  output logic carryBit
);
  localparam int NEG_COUNT = int'(NEG_MASK[0]) + int'(NEG_MASK[1]) + int'(NEG_MASK[2]);
  localparam logic SUM_INV   = (NEG_COUNT % 2) == 1;
  localparam logic CARRY_INV = NEG_COUNT >= 2;

  logic [2:0] rawIn;
  logic [2:0] adjIn;
  logic       faSum;
  logic       faCarry;

  assign rawIn   = {inC, inB, inA};
  assign adjIn   = rawIn ^ NEG_MASK;
  assign faSum   = ^adjIn;
  assign faCarry = (adjIn[0] & adjIn[1]) | (adjIn[0] & adjIn[2]) | (adjIn[1] & adjIn[2]);

  assign sumBit   = faSum ^ SUM_INV;
  assign carryBit = faCarry ^ CARRY_INV;
endmodule

// File: rtl/nbGhaCell.sv
// Half adder with one positive and one negative input. The variant decides
// which output carries the negative sign.
module nbGhaCell
  import negabinPkg::*;
#(
  parameter ghaVariantE VARIANT = GHA_NEG_CARRY
) (
  input  logic posIn,
  input  logic negIn,
  output logic sumBit,
  output logic carryBit
);
  logic adjPos;
  logic adjNeg;
  logic haSum;

  generate
    if (VARIANT == GHA_NEG_CARRY) begin : gNegCarry
      // invert the positive input: sum positive, carry negative
      assign adjPos = ~posIn;
      assign adjNeg = negIn;
    end else begin : gNegSum
      // invert the negative input: sum negative, carry positive
      assign adjPos = posIn;
      assign adjNeg = ~negIn;
    end
  endgenerate

  assign haSum    = adjPos ^ adjNeg;
  assign sumBit   = ~haSum;
  assign carryBit = adjPos & adjNeg;
endmodule

// File: rtl/nbFullRow.sv
// First carry chain. Each position adds two same-sign digits and a carry
// that arrives with the opposite sign. The sum digits leave this row with
// inverted polarity.
module nbFullRow #(
  parameter int WIDTH = 6
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] flipDigits,
  output logic             carryOut
);
  logic [WIDTH:0] chain;

  assign chain[0] = 1'b0;

  generate
    for (genvar k = 0; k < WIDTH; k++) begin : gCell
      nbGfaCell #(.NEG_MASK(3'b100)) uCell (
        .inA     (opA[k]),
        .inB     (opB[k]),
        .inC     (chain[k]),
        .sumBit  (flipDigits[k]),
        .carryBit(chain[k+1])
      );
    end
  endgenerate

  assign carryOut = chain[WIDTH];
endmodule

// File: rtl/nbFixRow.sv
// Second carry chain. It turns the inverted-polarity digits back into
// proper radix -2 form.
module nbFixRow
  import negabinPkg::*;
#(
  parameter int WIDTH = 6
) (
  input  logic [WIDTH-1:0] flipDigits,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut
);
  logic [WIDTH:0] chain;

  assign chain[0] = 1'b0;

  generate
    for (genvar k = 0; k < WIDTH; k++) begin : gCell
      nbGhaCell #(.VARIANT(GHA_NEG_CARRY)) uCell (
        .posIn   (chain[k]),
        .negIn   (flipDigits[k]),
        .sumBit  (sum[k]),
        .carryBit(chain[k+1])
      );
    end
  endgenerate

  assign carryOut = chain[WIDTH];
endmodule

// File: rtl/negabinAdder.sv
module negabinAdder #(
  parameter int WIDTH = 6
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sum,
  output logic             overflow
);
  logic [WIDTH-1:0] flipDigits;
  logic             fullCarry;
  logic             fixCarry;

  nbFullRow #(.WIDTH(WIDTH)) uFullRow (
    .opA       (opA),
    .opB       (opB),
    .flipDigits(flipDigits),
    .carryOut  (fullCarry)
  );

  nbFixRow #(.WIDTH(WIDTH)) uFixRow (
    .flipDigits(flipDigits),
    .sum       (sum),
    .carryOut  (fixCarry)
  );

  // The leftover weight at position WIDTH is (fixCarry - fullCarry)*(-2)^WIDTH.
  // It is nonzero exactly when the two carry-outs differ.
  assign overflow = fullCarry ^ fixCarry;
endmodule

// File: rtl/negabinAdderChk.sv
module negabinAdderChk
  import negabinPkg::*;
#(
  parameter int WIDTH = 6
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [WIDTH-1:0] sum,
  input logic             overflow
);
  localparam int SPAN = 1 << WIDTH;

  int trueVal;
  int sumVal;

  always_comb begin
    trueVal = nbToInt(32'(opA), WIDTH) + nbToInt(32'(opB), WIDTH);
    sumVal  = nbToInt(32'(sum), WIDTH);

    // R1
    sum_value_chk: assert (overflow || (sumVal == trueVal));
    // R2
    ovf_range_chk: assert (overflow == ((trueVal > nbMaxVal(WIDTH)) || (trueVal < nbMinVal(WIDTH))));
    // R3
    wrap_chk: assert (!overflow || ((trueVal - sumVal) == SPAN) || ((sumVal - trueVal) == SPAN));
    // R4
    zero_operand_chk: assert ((opA != '0) || ((sum == opB) && !overflow));
    // R5
    lsb_parity_chk: assert (sum[0] == (opA[0] ^ opB[0]));
  end
endmodule

bind negabinAdder negabinAdderChk #(.WIDTH(WIDTH)) uChk (
  .opA     (opA),
  .opB     (opB),
  .sum     (sum),
  .overflow(overflow)
);

// File: tb/tb_negabinAdder.sv
module tb_negabinAdder;
  localparam int W = 6;
  localparam int NVEC = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [W-1:0] opA, opB, sum;
  logic overflow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  negabinAdder #(.WIDTH(W)) dut (
    .opA(opA), .opB(opB), .sum(sum), .overflow(overflow)
  );

  // {a, b, expected sum, expected overflow}
  localparam logic [3*W:0] VEC [NVEC] = '{
    {6'b000000, 6'b000000, 6'b000000, 1'b0},
    {6'b000001, 6'b000001, 6'b000110, 1'b0},
    {6'b000011, 6'b000001, 6'b000000, 1'b0},
    {6'b010101, 6'b000000, 6'b010101, 1'b0},
    {6'b010101, 6'b000001, 6'b101010, 1'b1},
    {6'b101010, 6'b000000, 6'b101010, 1'b0},
    {6'b101010, 6'b000011, 6'b010101, 1'b1},
    {6'b010101, 6'b101010, 6'b111111, 1'b0},
    {6'b111111, 6'b111111, 6'b101010, 1'b0},
    {6'b010101, 6'b010101, 6'b111110, 1'b1},
    {6'b000111, 6'b000111, 6'b011010, 1'b0}
  };

  function automatic int valOf(input logic [W-1:0] d);
    int acc = 0;
    int w = 1;
    for (int i = 0; i < W; i++) begin
      if (d[i]) acc += w;
      w = w * -2;
    end
    return acc;
  endfunction

  function automatic logic [W-1:0] encode(input int v);
    logic [15:0] d = '0;
    int r;
    for (int i = 0; i < 16; i++) begin
      r = v & 1;
      d[i] = r[0];
      v = (v - r) / -2;
    end
    return d[W-1:0];
  endfunction

  task automatic checkOut(input string req, input logic [W-1:0] expSum, input logic expOvf);
    checks++;
    if (sum !== expSum || overflow !== expOvf) begin
      errors++;
      $display("FAIL %s a=%b b=%b actual sum=%b ovf=%b expected sum=%b ovf=%b",
               req, opA, opB, sum, overflow, expSum, expOvf);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b);
    @(posedge clk);
    opA = a;
    opB = b;
    @(negedge clk);
  endtask

  initial begin
    opA = '0;
    opB = '0;
    repeat (2) @(posedge clk);
    rst = 1'b0;

    // R4: idle state, both operands zero
    apply('0, '0);
    checkOut("R4", '0, 1'b0);

    // R1 R2 R3: hand-worked table, incl. range ends 21 and -42
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][3*W:2*W+1], VEC[i][2*W:W+1]);
      checkOut(VEC[i][0] ? "R3" : "R1", VEC[i][W:1], VEC[i][0]);
    end

    // R6: same table with operands swapped
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][2*W:W+1], VEC[i][3*W:2*W+1]);
      checkOut("R6", VEC[i][W:1], VEC[i][0]);
    end

    // R4: zero first operand passes the second through
    for (int b = 0; b < (1 << W); b++) begin
      apply('0, W'(b));
      checkOut("R4", W'(b), 1'b0);
    end

    // R1 R2 R3 R5: exhaustive sweep against an integer model
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        int t;
        logic expOvf;
        apply(W'(a), W'(b));
        t = valOf(W'(a)) + valOf(W'(b));
        expOvf = (t > 21) || (t < -42);
        checkOut(expOvf ? "R2/R3" : "R1/R2", encode(t), expOvf);
        checks++;
        if (sum[0] !== (opA[0] ^ opB[0])) begin
          errors++;
          $display("FAIL R5 actual=%b expected=%b", sum[0], opA[0] ^ opB[0]);
        end
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule